// File: doc/BRIEF.md
# PPU bank and nametable mapper

This block sits between the picture processor's address bus and the character memory of a game cartridge. From the four upper address lines (A13 down to A10) and a set of software-written registers it produces the upper address bits of the character ROM. It also produces the chip enable and the A10 line of the console's internal nametable RAM. Software writes one mode byte and eight bank registers, numbered r0 to r7. The block then answers every address combinationally from that stored state.

The mode byte does three jobs. It sets how finely the 8 KiB pattern space is banked. It chooses whether the four 1 KiB nametable screens (addresses 0x2000 to 0x2FFF, A13 high) come from the internal RAM or from banked ROM. It also sets how those screens are arranged: one of four fixed RAM mirrorings, one of two ROM layouts of r6/r7 with a forced low bank bit, or, in the 2 KiB grain, a free choice per screen taken from r4 to r7.

Top module: `ppu_bank_mapper`

## Requirements
- R1: After reset all registers are zero. A pattern access gives bank 0. A nametable access selects the internal RAM (`ciram_ce_n`=0) with `ciram_a10` equal to PPU A10.
- R2: On a rising clock edge, `cfg_we` stores `cfg_wdata` as the mode byte and `bank_we` stores `bank_wdata` into register r[`bank_sel`]. The new contents govern the outputs from that edge on.
- R3: Mode byte bits 1:0 (grain) = 0 and A13=0: `chr_bank` = r[A12:A10].
- R4: Grain = 1 and A13=0: `chr_bank` = r[A12:A11], so each 2 KiB half-pair shares one register.
- R5: Grain = 2 or 3 and A13=0: windows 0 to 3 use r0 to r3, windows 4 and 5 use r4, windows 6 and 7 use r5.
- R6: `ciram_ce_n` is 0 exactly when A13=1 and mode bit 4 (ROM nametables) is 0. While it is 0, `chr_bank` is 0. While it is 1, `ciram_a10` is 0.
- R7: Grain other than 1, RAM nametables: mode bits 3:2 select `ciram_a10`. 0 gives A10 (vertical), 1 gives A11 (horizontal), 2 gives a constant 0 and 3 gives a constant 1.
- R8: Grain = 1, RAM nametables: screen A11:A10 = k takes `ciram_a10` from bit 0 of r[4+k].
- R9: Grain = 1, ROM nametables: screen k gives `chr_bank` = r[4+k].
- R10: Grain other than 1, ROM nametables. With mode bit 2 = 0, `chr_bank` is r6 for A10=0 and r7 for A10=1, with its bit 0 replaced by A10. With mode bit 2 = 1, the choice and the replaced bit follow A11 instead. Mode bit 3 has no effect here.
- R11: Mode bits 7, 6 and 5 never change any output. In grain 1, mode bits 3:2 never change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode byte write strobe |
| cfg_wdata | input | 8 | Mode byte value |
| bank_we | input | 1 | Bank register write strobe |
| bank_sel | input | 3 | Bank register number |
| bank_wdata | input | BANK_W | Bank register value |
| ppu_a | input | 4 | PPU address bits A13 (bit 3) down to A10 (bit 0) |
| chr_bank | output | BANK_W | Character ROM upper address bits |
| ciram_ce_n | output | 1 | Internal nametable RAM enable, active low |
| ciram_a10 | output | 1 | Internal nametable RAM A10 |

## Verification
The bank registers are loaded with eight distinct values whose low bits differ. As a result, choosing the wrong register, pairing windows wrongly, or forcing the wrong bit in a ROM layout each shows as a different output value. All sixteen address values are swept under every combination of grain, nametable source and arrangement bits. This separates the pattern-grain cases from the nametable cases and the RAM path from the ROM path. Further sweeps set the three inert mode bits, vary the arrangement bits in the 2 KiB grain, and rewrite single registers to show that a write takes effect.

// File: rtl/ppu_map_pkg.sv
package ppu_map_pkg;

    localparam int NUM_BANKS = 8;
    localparam int SEL_W     = $clog2(NUM_BANKS);
    localparam int SLOT_W    = 3;
    localparam int NUM_SCR   = 4;

    // Pattern banking grain (mode byte bits 1:0)
    typedef enum logic [1:0] {
        GRAIN_1K   = 2'd0,
        GRAIN_2K   = 2'd1,
        GRAIN_MIX2 = 2'd2,
        GRAIN_MIX3 = 2'd3
    } grain_e;

    // Nametable arrangement (mode byte bits 3:2)
    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    // Mode byte, most significant field first
    typedef struct packed {
        logic    keep_w;
        logic    spare;
        logic    keep_p;
        logic    rom_nt;
        mirror_e mirror;
        grain_e  grain;
    } ctrl_t;

endpackage

// File: rtl/ppu_map_regs.sv
module ppu_map_regs
    import ppu_map_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [7:0]                       cfg_wdata,
    input  logic                             bank_we,
    input  logic [SEL_W-1:0]                 bank_sel,
    input  logic [BANK_W-1:0]                bank_wdata,
    output ctrl_t                            ctrl_q,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q
);

    typedef struct packed {
        ctrl_t                            ctrl;
        logic [NUM_BANKS-1:0][BANK_W-1:0] bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.ctrl = ctrl_t'(cfg_wdata);
        end
        if (bank_we) begin
            st_d.bank[bank_sel] = bank_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;
    assign bank_q = st_q.bank;

endmodule

// File: rtl/ppu_pat_map.sv
module ppu_pat_map
    import ppu_map_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  grain_e                           grain,
    input  logic [SLOT_W-1:0]                slot,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] bank,
    output logic [BANK_W-1:0]                pat_bank
);

    localparam int HALF = NUM_BANKS / 2;

    logic [NUM_BANKS-1:0][BANK_W-1:0] win_fine;
    logic [NUM_BANKS-1:0][BANK_W-1:0] win_pair;
    logic [NUM_BANKS-1:0][BANK_W-1:0] win_mix;

    // Per-window register choice for each grain
    for (genvar w = 0; w < NUM_BANKS; w++) begin : g_win
        localparam int PAIR_IDX = w / 2;
        localparam int MIX_IDX  = (w < HALF) ? w : HALF + (w - HALF) / 2;
        assign win_fine[w] = bank[w];
        assign win_pair[w] = bank[PAIR_IDX];
        assign win_mix[w]  = bank[MIX_IDX];
    end

    always_comb begin
        unique case (grain)
            GRAIN_1K: pat_bank = win_fine[slot];
            GRAIN_2K: pat_bank = win_pair[slot];
            default:  pat_bank = win_mix[slot];
        endcase
    end

endmodule

// File: rtl/ppu_nt_map.sv
module ppu_nt_map
    import ppu_map_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  grain_e                         grain,
    input  mirror_e                        mirror,
    input  logic [1:0]                     screen,
    input  logic [NUM_SCR-1:0][BANK_W-1:0] nt_bank,   // r4..r7
    output logic                           nt_a10,
    output logic [BANK_W-1:0]              nt_rom_bank
);

    logic [NUM_SCR-1:0][BANK_W-1:0] rom_alt;   // r6 r7 r6 r7, bit 0 <- A10
    logic [NUM_SCR-1:0][BANK_W-1:0] rom_pair;  // r6 r6 r7 r7, bit 0 <- A11
    logic [NUM_SCR-1:0]             free_a10;
    logic                           mir_a10;

    for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
        localparam int ALT_SRC  = 2 + (s % 2);
        localparam int PAIR_SRC = 2 + (s / 2);
        localparam bit ALT_BIT  = (s % 2) != 0;
        localparam bit PAIR_BIT = (s / 2) != 0;
        assign rom_alt[s]  = {nt_bank[ALT_SRC][BANK_W-1:1], ALT_BIT};
        assign rom_pair[s] = {nt_bank[PAIR_SRC][BANK_W-1:1], PAIR_BIT};
        assign free_a10[s] = nt_bank[s][0];
    end

    always_comb begin
        unique case (mirror)
            MIR_VERT:   mir_a10 = screen[0];
            MIR_HORZ:   mir_a10 = screen[1];
            MIR_ONE_LO: mir_a10 = 1'b0;
            default:    mir_a10 = 1'b1;
        endcase
    end

    always_comb begin
        if (grain == GRAIN_2K) begin
            nt_a10      = free_a10[screen];
            nt_rom_bank = nt_bank[screen];
        end else begin
            nt_a10      = mir_a10;
            nt_rom_bank = mirror[0] ? rom_pair[screen] : rom_alt[screen];
        end
    end

endmodule

// File: rtl/ppu_bank_mapper.sv
module ppu_bank_mapper
    import ppu_map_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              bank_we,
    input  logic [2:0]        bank_sel,
    input  logic [BANK_W-1:0] bank_wdata,
    input  logic [3:0]        ppu_a,
    output logic [BANK_W-1:0] chr_bank,
    output logic              ciram_ce_n,
    output logic              ciram_a10
);

    ctrl_t                            ctrl_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
    logic [BANK_W-1:0]                pat_bank;
    logic [BANK_W-1:0]                nt_rom_bank;
    logic                             nt_a10;
    logic                             nt_hit;
    logic                             unused_ctrl_bits;

    ppu_map_regs #(.BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .bank_we    (bank_we),
        .bank_sel   (bank_sel),
        .bank_wdata (bank_wdata),
        .ctrl_q     (ctrl_q),
        .bank_q     (bank_q)
    );

    ppu_pat_map #(.BANK_W(BANK_W)) u_pat (
        .grain    (ctrl_q.grain),
        .slot     (ppu_a[SLOT_W-1:0]),
        .bank     (bank_q),
        .pat_bank (pat_bank)
    );

    ppu_nt_map #(.BANK_W(BANK_W)) u_nt (
        .grain       (ctrl_q.grain),
        .mirror      (ctrl_q.mirror),
        .screen      (ppu_a[1:0]),
        .nt_bank     (bank_q[NUM_BANKS-1:NUM_BANKS-NUM_SCR]),
        .nt_a10      (nt_a10),
        .nt_rom_bank (nt_rom_bank)
    );

    // Stored mode bits that steer nothing
    assign unused_ctrl_bits = ^{ctrl_q.keep_w, ctrl_q.spare, ctrl_q.keep_p};

    assign nt_hit = ppu_a[3];

    always_comb begin
        if (!nt_hit) begin
            chr_bank   = pat_bank;
            ciram_ce_n = 1'b1;
            ciram_a10  = 1'b0;
        end else if (!ctrl_q.rom_nt) begin
            chr_bank   = '0;
            ciram_ce_n = 1'b0;
            ciram_a10  = nt_a10;
        end else begin
            chr_bank   = nt_rom_bank;
            ciram_ce_n = 1'b1;
            ciram_a10  = 1'b0;
        end
    end

endmodule

// File: rtl/ppu_map_checker.sv
module ppu_map_checker #(
    parameter int BANK_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [3:0]            ppu_a,
    input logic [BANK_W-1:0]     chr_bank,
    input logic                  ciram_ce_n,
    input logic                  ciram_a10,
    input logic [7:0]            ctrl,
    input logic [7:0][BANK_W-1:0] bank
);

    AST_RAM_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ciram_ce_n) == (ppu_a[3] && !ctrl[4]));                         // R6
    AST_RAM_CHR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ciram_ce_n |-> (chr_bank == '0));                                 // R6
    AST_ROM_A10_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ciram_ce_n |-> !ciram_a10);                                        // R6
    AST_FINE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppu_a[3] && ctrl[1:0] == 2'd0) |-> (chr_bank == bank[ppu_a[2:0]])); // R3
    AST_PAIR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppu_a[3] && ctrl[1:0] == 2'd1) |-> (chr_bank == bank[{1'b0, ppu_a[2:1]}])); // R4
    AST_ROM_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_a[3] && ctrl[4] && ctrl[1:0] != 2'd1)
            |-> (chr_bank[0] == (ctrl[2] ? ppu_a[1] : ppu_a[0])));         // R10
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ctrl));                                        // R2

endmodule

bind ppu_bank_mapper ppu_map_checker #(.BANK_W(BANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .ppu_a      (ppu_a),
    .chr_bank   (chr_bank),
    .ciram_ce_n (ciram_ce_n),
    .ciram_a10  (ciram_a10),
    .ctrl       (ctrl_q),
    .bank       (bank_q)
);

// File: tb/ppu_bank_mapper_test.sv
module ppu_bank_mapper_test;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic          bank_we = 1'b0;
    logic [2:0]    bank_sel = '0;
    logic [BW-1:0] bank_wdata = '0;
    logic [3:0]    ppu_a = '0;
    logic [BW-1:0] chr_bank;
    logic          ciram_ce_n;
    logic          ciram_a10;

    ppu_bank_mapper #(.BANK_W(BW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .bank_we    (bank_we),
        .bank_sel   (bank_sel),
        .bank_wdata (bank_wdata),
        .ppu_a      (ppu_a),
        .chr_bank   (chr_bank),
        .ciram_ce_n (ciram_ce_n),
        .ciram_a10  (ciram_a10)
    );

    always #2 clk = ~clk;   // 250 MHz

    typedef struct {
        logic [3:0]    a;
        logic [BW-1:0] chr;
        logic          ce_n;
        logic          a10;
        string         req;
    } exp_t;

    exp_t          sbq[$];
    int            applied = 0;
    int            bad = 0;
    bit            done = 1'b0;
    logic [7:0]    m_ctl = '0;
    logic [BW-1:0] m_bk[8];

    // Reference model written from the requirements
    function automatic exp_t model(logic [3:0] a);
        exp_t e;
        logic [1:0] d = m_ctl[1:0];
        logic [1:0] m = m_ctl[3:2];
        logic       n = m_ctl[4];
        int         idx;
        e.a = a;
        if (!a[3]) begin
            e.ce_n = 1'b1;
            e.a10  = 1'b0;
            if (d == 2'd0) begin
                idx = int'(a[2:0]); e.req = "R3";
            end else if (d == 2'd1) begin
                idx = int'(a[2:1]); e.req = "R4";
            end else begin
                idx = a[2] ? 4 + int'(a[1]) : int'(a[2:0]); e.req = "R5";
            end
            e.chr = m_bk[idx];
        end else if (!n) begin
            e.ce_n = 1'b0;
            e.chr  = '0;
            if (d == 2'd1) begin
                e.a10 = m_bk[4 + int'(a[1:0])][0]; e.req = "R8";
            end else begin
                case (m)
                    2'd0:    e.a10 = a[0];
                    2'd1:    e.a10 = a[1];
                    2'd2:    e.a10 = 1'b0;
                    default: e.a10 = 1'b1;
                endcase
                e.req = "R7";
            end
        end else begin
            e.ce_n = 1'b1;
            e.a10  = 1'b0;
            if (d == 2'd1) begin
                e.chr = m_bk[4 + int'(a[1:0])]; e.req = "R9";
            end else if (m[0]) begin
                e.chr = {m_bk[6 + int'(a[1])][BW-1:1], a[1]}; e.req = "R10";
            end else begin
                e.chr = {m_bk[6 + int'(a[0])][BW-1:1], a[0]}; e.req = "R10";
            end
        end
        return e;
    endfunction

    task automatic put_cfg(input logic [7:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_ctl = v;
    endtask

    task automatic put_bank(input int i, input logic [BW-1:0] v);
        @(posedge clk); #1;
        bank_we = 1'b1; bank_sel = 3'(i); bank_wdata = v;
        @(posedge clk); #1;
        bank_we = 1'b0;
        m_bk[i] = v;
    endtask

    // Driver: sets the address and queues the expected result
    task automatic drive(input logic [3:0] a, input string tag);
        exp_t e;
        @(posedge clk); #1;
        ppu_a = a;
        e = model(a);
        if (tag != "") e.req = tag;
        sbq.push_back(e);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 16; a++) drive(4'(a), tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    // Monitor: pops and compares between clock edges
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                applied++;
                if (ciram_ce_n !== e.ce_n) begin
                    bad++;
                    $display("FAIL R6 (%s) a=%h: ce_n=%b a10=%b chr=%h, expected ce_n=%b a10=%b chr=%h",
                             e.req, e.a, ciram_ce_n, ciram_a10, chr_bank, e.ce_n, e.a10, e.chr);
                end else if (chr_bank !== e.chr || ciram_a10 !== e.a10) begin
                    bad++;
                    $display("FAIL %s a=%h mode=%h: chr=%h a10=%b, expected chr=%h a10=%b",
                             e.req, e.a, m_ctl, chr_bank, ciram_a10, e.chr, e.a10);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=run complete");
            finish_run();
        end
    end

    initial begin
        logic [BW-1:0] vals[8];
        vals = '{8'hA1, 8'h32, 8'h5C, 8'h47, 8'hE8, 8'h9B, 8'h6E, 8'hD5};
        for (int i = 0; i < 8; i++) m_bk[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: state right after reset
        sweep("R1");

        for (int i = 0; i < 8; i++) put_bank(i, vals[i]);

        // R3..R10: every grain, source and arrangement
        for (int d = 0; d < 4; d++)
            for (int n = 0; n < 2; n++)
                for (int m = 0; m < 4; m++) begin
                    put_cfg({3'b000, 1'(n), 2'(m), 2'(d)});
                    sweep("");
                end

        // R11: inert mode bits set
        for (int d = 0; d < 4; d++)
            for (int n = 0; n < 2; n++) begin
                put_cfg({3'b111, 1'(n), 2'b01, 2'(d)});
                sweep("R11");
            end

        // R11: arrangement bits in the 2 KiB grain
        for (int n = 0; n < 2; n++)
            for (int m = 0; m < 4; m++) begin
                put_cfg({3'b000, 1'(n), 2'(m), 2'b01});
                for (int a = 8; a < 16; a++) drive(4'(a), "R11");
            end

        // R2: single register rewrites take effect
        put_cfg(8'h00);
        put_bank(3, 8'h77);
        drive(4'b0011, "R2");
        put_cfg(8'h10);
        put_bank(6, 8'hF1);
        drive(4'b1000, "R2");
        drive(4'b1010, "R2");
        put_cfg(8'h01);
        drive(4'b0110, "R2");

        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule